// File: doc/BRIEF.md
# Predicate First-Active Setter

This block applies one operation to a vector predicate: it finds the lowest set bit of a guard predicate and sets that same bit in a destination predicate. Each predicate has one bit per byte of the vector, so a 2048-bit vector gives a 256-bit predicate. Every other destination bit passes through unchanged. Four condition flags are then derived from the updated destination, seen through the guard.

A caller presents both predicates with a one-cycle `start`. One cycle later, `done` pulses with the new destination and the flags. The outputs keep those values until the next `start`. Internally, the predicate is handled as a row of 64-bit words. Each word isolates its own lowest and highest guard bits. A word-level prefix chain then picks the word that holds the first guard bit overall and the word that holds the last.

Top module: `pfa_setter`

## Requirements
- R1: The bit of `dest_out` at the position of the lowest set bit of `guard_in`, over the whole predicate, is 1 after the operation, and no more than one bit differs from `dest_in`.
- R2: Every `dest_out` bit other than the one named in R1 equals the matching `dest_in` bit. This includes every bit in words above and below the selected word.
- R3: When `guard_in` is all zero, `dest_out` equals `dest_in`, and the flags are `flag_n`=0, `flag_z`=1, `flag_c`=1, `flag_v`=0.
- R4: `flag_n` equals the `dest_out` bit at the lowest guard-active position, so it is 1 whenever the guard is non-zero.
- R5: `flag_z` is 1 exactly when no `dest_out` bit is set at any position where `guard_in` is set.
- R6: `flag_c` is 1 exactly when the `dest_out` bit at the highest guard-active position is 0, or when the guard is empty.
- R7: `flag_v` is always 0.
- R8: `done` is 1 in the cycle after each cycle with `start`=1 and 0 otherwise. The results of that start are on the outputs while `done` is 1, including when two starts are back to back.
- R9: Without `start`, `dest_out` and the flags hold their last values whatever `guard_in` and `dest_in` do.
- R10: After reset, `done`=0, `dest_out`=0, `flag_n`=0, `flag_z`=1, `flag_c`=1 and `flag_v`=0.
- R11: The search crosses 64-bit word boundaries: a lowest guard bit in any word, including a partial top word, is found. When the guard has bits in several words, only the lowest word is affected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| start | input | 1 | Begin an operation on the current inputs |
| guard_in | input | PRED_BITS | Guard predicate |
| dest_in | input | PRED_BITS | Destination predicate before the operation |
| done | output | 1 | One-cycle result strobe |
| dest_out | output | PRED_BITS | Destination predicate after the operation |
| flag_n | output | 1 | Result bit at the first guard-active position |
| flag_z | output | 1 | No result bit active under the guard |
| flag_c | output | 1 | Result bit at the last guard-active position is clear |
| flag_v | output | 1 | Always zero |

## Verification
The bench builds the block with `PRED_BITS`=160. This gives three 64-bit words, and the top word is only half used. Test vectors can therefore place the first guard bit in the lowest, middle and partial top word. They can also straddle the boundary between word 0 and word 1 and use the highest legal bit, 159. This exercises both prefix chains and the zero padding of the unused high bits. Expected results come from a bit-serial model of the requirements in the bench.

// File: rtl/pfa_pkg.sv
package pfa_pkg;

  localparam int WORD_W = 64;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } pfa_flags_t;

  localparam pfa_flags_t FLAGS_EMPTY = '{n: 1'b0, z: 1'b1, c: 1'b1, v: 1'b0};

  // Lowest set bit of a word, alone.
  function automatic logic [WORD_W-1:0] iso_low(input logic [WORD_W-1:0] w);
    return w & (~w + {{(WORD_W-1){1'b0}}, 1'b1});
  endfunction

  // Highest set bit of a word, alone.
  function automatic logic [WORD_W-1:0] iso_high(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) begin
      if (w[i]) begin
        r    = '0;
        r[i] = 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/pfa_word_unit.sv
module pfa_word_unit
  import pfa_pkg::*;
(
  input  logic [WORD_W-1:0] g_word,
  input  logic [WORD_W-1:0] d_word,
  input  logic              is_first,
  output logic              g_any,
  output logic [WORD_W-1:0] d_next,
  output logic              hit_low,
  output logic              hit_high,
  output logic              hit_any
);

  logic [WORD_W-1:0] low_bit;
  logic [WORD_W-1:0] high_bit;

  always_comb begin
    low_bit  = iso_low(g_word);
    high_bit = iso_high(g_word);
    g_any    = |g_word;
    d_next   = is_first ? (d_word | low_bit) : d_word;
    hit_low  = |(d_next & low_bit);
    hit_high = |(d_next & high_bit);
    hit_any  = |(d_next & g_word);
  end

endmodule

// File: rtl/pfa_chain.sv
module pfa_chain #(
  parameter int NWORDS = 4
) (
  input  logic [NWORDS-1:0] any_word,
  output logic [NWORDS-1:0] first_word,
  output logic [NWORDS-1:0] last_word
);

  logic [NWORDS:0] seen_below;
  logic [NWORDS:0] seen_above;

  assign seen_below[0]      = 1'b0;
  assign seen_above[NWORDS] = 1'b0;

  for (genvar k = 0; k < NWORDS; k++) begin : g_up
    assign seen_below[k+1] = seen_below[k] | any_word[k];
    assign first_word[k]   = any_word[k] & ~seen_below[k];
  end

  for (genvar k = NWORDS - 1; k >= 0; k--) begin : g_down
    assign seen_above[k] = seen_above[k+1] | any_word[k];
    assign last_word[k]  = any_word[k] & ~seen_above[k+1];
  end

endmodule

// File: rtl/pfa_flag_merge.sv
module pfa_flag_merge
  import pfa_pkg::*;
#(
  parameter int NWORDS = 4
) (
  input  logic [NWORDS-1:0] first_word,
  input  logic [NWORDS-1:0] last_word,
  input  logic [NWORDS-1:0] hit_low,
  input  logic [NWORDS-1:0] hit_high,
  input  logic [NWORDS-1:0] hit_any,
  output pfa_flags_t        flags
);

  always_comb begin
    flags.n = |(first_word & hit_low);
    flags.z = ~|hit_any;
    flags.c = ~|(last_word & hit_high);
    flags.v = 1'b0;
  end

endmodule

// File: rtl/pfa_setter.sv
module pfa_setter
  import pfa_pkg::*;
#(
  parameter int PRED_BITS = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PRED_BITS-1:0] guard_in,
  input  logic [PRED_BITS-1:0] dest_in,
  output logic                 done,
  output logic [PRED_BITS-1:0] dest_out,
  output logic                 flag_n,
  output logic                 flag_z,
  output logic                 flag_c,
  output logic                 flag_v
);

  localparam int NWORDS = (PRED_BITS + WORD_W - 1) / WORD_W;
  localparam int PAD_W  = NWORDS * WORD_W;

  logic [PAD_W-1:0]  g_pad;
  logic [PAD_W-1:0]  d_pad;
  logic [PAD_W-1:0]  d_new_pad;
  logic [NWORDS-1:0] any_word;
  logic [NWORDS-1:0] first_word;
  logic [NWORDS-1:0] last_word;
  logic [NWORDS-1:0] hit_low;
  logic [NWORDS-1:0] hit_high;
  logic [NWORDS-1:0] hit_any;
  pfa_flags_t        flags_calc;

  logic                 done_q, done_d;
  logic [PRED_BITS-1:0] dest_q, dest_d;
  pfa_flags_t           flags_q, flags_d;
  logic                 load_en;

  // Unused high bits of the top word are zero.
  assign g_pad = PAD_W'(guard_in);
  assign d_pad = PAD_W'(dest_in);

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    pfa_word_unit u_word (
      .g_word   (g_pad[k*WORD_W +: WORD_W]),
      .d_word   (d_pad[k*WORD_W +: WORD_W]),
      .is_first (first_word[k]),
      .g_any    (any_word[k]),
      .d_next   (d_new_pad[k*WORD_W +: WORD_W]),
      .hit_low  (hit_low[k]),
      .hit_high (hit_high[k]),
      .hit_any  (hit_any[k])
    );
  end

  pfa_chain #(.NWORDS(NWORDS)) u_chain (
    .any_word   (any_word),
    .first_word (first_word),
    .last_word  (last_word)
  );

  pfa_flag_merge #(.NWORDS(NWORDS)) u_merge (
    .first_word (first_word),
    .last_word  (last_word),
    .hit_low    (hit_low),
    .hit_high   (hit_high),
    .hit_any    (hit_any),
    .flags      (flags_calc)
  );

  // Next-state logic
  always_comb begin
    load_en = start;
    done_d  = start;
    dest_d  = dest_q;
    flags_d = flags_q;
    if (load_en) begin
      dest_d  = d_new_pad[PRED_BITS-1:0];
      flags_d = flags_calc;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= 1'b0;
      dest_q  <= '0;
      flags_q <= FLAGS_EMPTY;
    end else begin
      done_q <= done_d;
      if (load_en) begin
        dest_q  <= dest_d;
        flags_q <= flags_d;
      end
    end
  end

  assign done     = done_q;
  assign dest_out = dest_q;
  assign flag_n   = flags_q.n;
  assign flag_z   = flags_q.z;
  assign flag_c   = flags_q.c;
  assign flag_v   = flags_q.v;

  assert_done_follows_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);

  assert_done_needs_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !done);

  assert_keep_dest_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ((dest_out & $past(dest_in)) == $past(dest_in)));

  assert_single_new_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> ($countones(dest_out ^ $past(dest_in)) <= 1));

  assert_zero_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && guard_in == '0) |=>
      (flag_z && flag_c && !flag_n && dest_out == $past(dest_in)));

  assert_first_bit_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && guard_in != '0) |=> (flag_n && !flag_z));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(dest_out) && $stable(flag_c)));

  assert_one_first_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_word) && $onehot0(last_word));

endmodule

// File: tb/test_pfa_setter.sv
module test_pfa_setter;

  localparam int W  = 160;
  localparam int NV = 9;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] guard_in;
  logic [W-1:0] dest_in;
  logic         done;
  logic [W-1:0] dest_out;
  logic         flag_n, flag_z, flag_c, flag_v;

  int checks;
  int failures;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  localparam logic [W-1:0] TG [NV] = '{
    '0,                                  // R3 empty guard
    '0,                                  // R3 empty guard, busy dest
    ONE,                                 // R1 bit 0
    (ONE << 70) | (ONE << 100),          // R11 second word
    ONE << 159,                          // R11 top partial word
    {W{1'b1}},                           // R5 all active
    (ONE << 63) | (ONE << 64),           // R11 straddle boundary
    (ONE << 130) | (ONE << 5),           // R2 dest all ones
    (ONE << 5) | (ONE << 6)              // R6 last already set
  };

  localparam logic [W-1:0] TD [NV] = '{
    '0,
    (ONE << 3) | (ONE << 150),
    '0,
    ONE << 2,
    ONE << 159,
    '0,
    ONE << 64,
    {W{1'b1}},
    ONE << 6
  };

  pfa_setter #(.PRED_BITS(W)) i_pfa_setter (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .guard_in (guard_in),
    .dest_in  (dest_in),
    .done     (done),
    .dest_out (dest_out),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_c   (flag_c),
    .flag_v   (flag_v)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Bit-serial model of the requirements.
  task automatic model(input logic [W-1:0] g, input logic [W-1:0] d,
                       output logic [W-1:0] nd, output logic [3:0] f);
    int lo;
    int hi;
    lo = -1;
    hi = -1;
    nd = d;
    for (int i = 0; i < W; i++) begin
      if (g[i]) begin
        if (lo < 0) lo = i;
        hi = i;
      end
    end
    if (lo >= 0) nd[lo] = 1'b1;
    f[3] = (lo >= 0) ? nd[lo] : 1'b0;
    f[2] = ((nd & g) == '0);
    f[1] = (hi >= 0) ? ~nd[hi] : 1'b1;
    f[0] = 1'b0;
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [3:0] exp);
    checks++;
    if ({flag_n, flag_z, flag_c, flag_v} !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, {flag_n, flag_z, flag_c, flag_v}, exp);
    end
  endtask

  task automatic run_one(input logic [W-1:0] g, input logic [W-1:0] d);
    logic [W-1:0] nd;
    logic [3:0]   f;
    model(g, d, nd, f);
    @(negedge clk);
    guard_in = g;
    dest_in  = d;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk_bit("R8 done after start", done, 1'b1);
    chk_vec("R1 R2 R11 dest_out", dest_out, nd);
    chk_flags("R3 R4 R5 R6 R7 flags", f);
  endtask

  initial begin
    logic [W-1:0] nd_a, nd_b;
    logic [3:0]   f_a, f_b;
    checks   = 0;
    failures = 0;
    rst_n    = 1'b0;
    start    = 1'b0;
    guard_in = '0;
    dest_in  = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_bit("R10 done", done, 1'b0);
    chk_vec("R10 dest_out", dest_out, '0);
    chk_flags("R10 flags", 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_one(TG[v], TD[v]);
    end

    // R8 done lasts one cycle; R9 results hold with inputs changing
    model(TG[NV-1], TD[NV-1], nd_a, f_a);
    guard_in = ONE << 1;
    dest_in  = ~TD[NV-1];
    @(negedge clk);
    chk_bit("R8 done drops", done, 1'b0);
    @(negedge clk);
    chk_vec("R9 dest_out holds", dest_out, nd_a);
    chk_flags("R9 flags hold", f_a);

    // R8 back-to-back starts
    model(ONE << 90, '0, nd_a, f_a);
    model((ONE << 10) | (ONE << 140), ONE << 140, nd_b, f_b);
    guard_in = ONE << 90;
    dest_in  = '0;
    start    = 1'b1;
    @(negedge clk);
    guard_in = (ONE << 10) | (ONE << 140);
    dest_in  = ONE << 140;
    chk_bit("R8 first of pair done", done, 1'b1);
    chk_vec("R8 first of pair dest", dest_out, nd_a);
    @(negedge clk);
    start = 1'b0;
    chk_bit("R8 second of pair done", done, 1'b1);
    chk_vec("R8 second of pair dest", dest_out, nd_b);
    chk_flags("R6 second of pair flags", f_b);
    @(negedge clk);
    chk_bit("R8 pair done drops", done, 1'b0);

    // R10 reset mid-run returns to the reset state
    rst_n = 1'b0;
    @(negedge clk);
    chk_vec("R10 dest after reset", dest_out, '0);
    chk_flags("R10 flags after reset", 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule